// File: doc/BRIEF.md
# Prioritised external interrupt hub with scaled vector index

This block gathers 32 level-sensitive external interrupt lines for a processor core and presents one external-interrupt request. Each line has a software enable and a 4-bit priority. A line's pending state is its input level, so a source that drops its line withdraws its request. A combinational arbiter picks one winner among the lines that are pending, enabled and at or above the current preemption level. The higher priority wins, and on equal priority the lower line number wins. The winner is reported through a "next interrupt" value that holds the line number times four, ready for indexing a table of 32-bit vectors. When no line qualifies, bit 31 of that value is set.

A small two-state machine tracks whether a handler is running. In `ST_RUN` no handler is active. The transition `TAKE` (a take strobe while the request is high) moves it to `ST_SERVE`. On that transition it saves the current level, raises the level to one above the winner's priority, drops the request on the following edge and latches the cause value 0x8000000B. The transition `RETURN` (a return strobe in `ST_SERVE`) restores the saved level and goes back to `ST_RUN`. A take strobe in `ST_SERVE` and a return strobe in `ST_RUN` are both ignored.

Software reads the pending lines through a 16-bit window. It also reads a status word in which bit 7 mirrors the timer-pending input and bit 11 mirrors the external request.

Top module: `vec_irq_hub`

## Requirements
- R1: After reset, all enables and priorities are 0, `ext_req` is 0, `cause` is 0, `cur_level` is 0 and `serving` is 0.
- R2: `win_data` returns pending lines 15:0 when `win_sel` is 0, and lines 31:16 when `win_sel` is 1.
- R3: When a winner n exists, `next_irq` equals 4*n (bits 6:0) with bit 31 clear. When no line qualifies, `next_irq` equals 0x80000000.
- R4: A line qualifies when it is pending, enabled and its priority is at least `cur_level`. Among qualifying lines the higher priority wins, and ties go to the lower line number.
- R5: `ext_req` is registered. It is 1 on the edge after some line qualifies, and 0 on the edge after none does.
- R6: In `ST_RUN`, a `take` strobe while `ext_req` is 1 sets `cur_level` to the winner's priority plus one, sets `cause` to 0x8000000B, sets `serving`, and makes `ext_req` read 0 right after that same edge.
- R7: `status` bit 7 equals `timer_pend`, bit 11 equals `ext_req`, and all other bits are 0. Taking an interrupt does not change bit 7.
- R8: A `ret` strobe in `ST_SERVE` restores `cur_level` to the value saved at the take and clears `serving`. `ret` in `ST_RUN` and `take` in `ST_SERVE` leave the level and the state unchanged.
- R9: With all lines held high, enabling the lines one at a time from 31 down to 0 gives exactly one request per newly enabled line, provided each handler lowers its own line before returning.
- R10: Lowering a line clears its pending bit, and that line is no longer offered in `next_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 32 | Level interrupt inputs (pending state) |
| timer_pend | input | 1 | Timer pending level, shown in status bit 7 |
| en_we | input | 1 | Enable write strobe |
| en_idx | input | 5 | Line whose enable is written |
| en_bit | input | 1 | Enable value written |
| pri_we | input | 1 | Priority write strobe |
| pri_idx | input | 5 | Line whose priority is written |
| pri_val | input | 4 | Priority value written |
| win_sel | input | 1 | Pending window select |
| take | input | 1 | Core takes the external interrupt |
| ret | input | 1 | Core returns from the handler |
| win_data | output | 16 | Selected 16 pending bits |
| next_irq | output | 32 | Scaled winner index, with a none flag in bit 31 |
| status | output | 32 | Request status view |
| ext_req | output | 1 | Registered external interrupt request |
| cause | output | 32 | Cause value latched on take |
| cur_level | output | 5 | Current preemption level |
| serving | output | 1 | High in `ST_SERVE` |

## Verification
The assertions assume that strobes last one cycle and that `take` is asserted only while `ext_req` is high, as a core would do. They also assume the write indices stay in range. The stimulus drives every strobe for exactly one clock, issues each `take` only after it has seen the request, and uses 5-bit indices, so all 32 lines are valid. The ignored-strobe cases (`take` while serving, `ret` while running) are driven on purpose, because the machine has a defined response to them.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;
    localparam int unsigned NIRQ   = 32;
    localparam int unsigned PRIO_W = 4;
    localparam int unsigned WIN_W  = 16;
    localparam int unsigned IDX_W  = $clog2(NIRQ);
    localparam int unsigned LVL_W  = PRIO_W + 1;
    localparam logic [31:0] CAUSE_EXT = 32'h8000_000B;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_SERVE = 1'b1
    } hub_state_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import vec_irq_pkg::*;
#(
    parameter int unsigned N  = NIRQ,
    parameter int unsigned PW = PRIO_W,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_we,
    input  logic [IW-1:0]   en_idx,
    input  logic            en_bit,
    input  logic            pri_we,
    input  logic [IW-1:0]   pri_idx,
    input  logic [PW-1:0]   pri_val,
    output logic [N-1:0]    en_q,
    output logic [N*PW-1:0] prio_flat
);
    for (genvar g = 0; g < N; g++) begin : g_line
        logic [PW-1:0] prio_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[g] <= 1'b0;
                prio_q  <= '0;
            end else begin
                if (en_we && en_idx == IW'(g))
                    en_q[g] <= en_bit;
                if (pri_we && pri_idx == IW'(g))
                    prio_q <= pri_val;
            end
        end

        assign prio_flat[g*PW +: PW] = prio_q;

        AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
            (en_we && en_idx == IW'(g)) |=> (en_q[g] == $past(en_bit))); // R1
    end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import vec_irq_pkg::*;
#(
    parameter int unsigned N  = NIRQ,
    parameter int unsigned PW = PRIO_W,
    localparam int unsigned IW = $clog2(N),
    localparam int unsigned LW = PW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    pend,
    input  logic [N-1:0]    en,
    input  logic [N*PW-1:0] prio_flat,
    input  logic [LW-1:0]   level,
    output logic            found,
    output logic [IW-1:0]   win_idx,
    output logic [PW-1:0]   win_prio
);
    logic [N-1:0] qual;

    for (genvar g = 0; g < N; g++) begin : g_qual
        assign qual[g] = pend[g] && en[g] &&
                         ({1'b0, prio_flat[g*PW +: PW]} >= level);
    end

    // Scan from the top line down; ">=" lets a lower line win a tie.
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (qual[i] && (!found || prio_flat[i*PW +: PW] >= win_prio)) begin
                found    = 1'b1;
                win_idx  = IW'(i);
                win_prio = prio_flat[i*PW +: PW];
            end
        end
    end

    AST_WINNER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (pend[win_idx] && en[win_idx])); // R4
    AST_WINNER_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> ({1'b0, win_prio} >= level)); // R4
    AST_NONE_MEANS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!found && level == '0) |-> ((pend & en) == '0)); // R4
endmodule

// File: rtl/irq_preempt_fsm.sv
module irq_preempt_fsm
    import vec_irq_pkg::*;
#(
    parameter int unsigned PW = PRIO_W,
    localparam int unsigned LW = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          ret,
    input  logic          req_now,
    input  logic [PW-1:0] take_prio,
    output logic          ext_req,
    output logic [LW-1:0] level,
    output logic [31:0]   cause,
    output logic          serving
);
    hub_state_e    st_q, st_d;
    logic [LW-1:0] saved_q;
    logic          do_take, do_ret;

    assign do_take = (st_q == ST_RUN) && take && ext_req;
    assign do_ret  = (st_q == ST_SERVE) && ret;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:   if (do_take) st_d = ST_SERVE;
            ST_SERVE: if (do_ret)  st_d = ST_RUN;
            default:  st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RUN;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_req <= 1'b0;
            level   <= '0;
            saved_q <= '0;
            cause   <= '0;
        end else begin
            ext_req <= req_now && !do_take;
            if (do_take) begin
                saved_q <= level;
                level   <= {1'b0, take_prio} + LW'(1);
                cause   <= CAUSE_EXT;
            end else if (do_ret) begin
                level <= saved_q;
            end
        end
    end

    assign serving = (st_q == ST_SERVE);

    AST_REQ_DROPS_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        do_take |=> !ext_req); // R6
    AST_CAUSE_ON_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        do_take |=> (cause == CAUSE_EXT)); // R6
    AST_LEVEL_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        do_take |=> (level > $past(level))); // R6
    AST_LEVEL_RESTORED: assert property (@(posedge clk) disable iff (!rst_n)
        do_ret |=> (level == $past(saved_q))); // R8
    AST_RET_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!serving && !do_take) |=> $stable(level)); // R8
endmodule

// File: rtl/vec_irq_hub.sv
module vec_irq_hub
    import vec_irq_pkg::*;
#(
    parameter int unsigned N  = NIRQ,
    parameter int unsigned PW = PRIO_W,
    parameter int unsigned WW = WIN_W,
    localparam int unsigned IW = $clog2(N),
    localparam int unsigned LW = PW + 1,
    localparam int unsigned NWIN = N / WW,
    localparam int unsigned SW = (NWIN > 1) ? $clog2(NWIN) : 1,
    localparam int unsigned PADW = 32 - 1 - IW - 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_lines,
    input  logic          timer_pend,
    input  logic          en_we,
    input  logic [IW-1:0] en_idx,
    input  logic          en_bit,
    input  logic          pri_we,
    input  logic [IW-1:0] pri_idx,
    input  logic [PW-1:0] pri_val,
    input  logic [SW-1:0] win_sel,
    input  logic          take,
    input  logic          ret,
    output logic [WW-1:0] win_data,
    output logic [31:0]   next_irq,
    output logic [31:0]   status,
    output logic          ext_req,
    output logic [31:0]   cause,
    output logic [LW-1:0] cur_level,
    output logic          serving
);
    logic [N-1:0]    en_q;
    logic [N*PW-1:0] prio_flat;
    logic            found;
    logic [IW-1:0]   pick_idx;
    logic [PW-1:0]   pick_prio;

    irq_cfg_regs #(.N(N), .PW(PW)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .en_we(en_we), .en_idx(en_idx), .en_bit(en_bit),
        .pri_we(pri_we), .pri_idx(pri_idx), .pri_val(pri_val),
        .en_q(en_q), .prio_flat(prio_flat)
    );

    irq_pick #(.N(N), .PW(PW)) u_pick (
        .clk(clk), .rst_n(rst_n),
        .pend(irq_lines), .en(en_q), .prio_flat(prio_flat),
        .level(cur_level),
        .found(found), .win_idx(pick_idx), .win_prio(pick_prio)
    );

    irq_preempt_fsm #(.PW(PW)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .take(take), .ret(ret),
        .req_now(found), .take_prio(pick_prio),
        .ext_req(ext_req), .level(cur_level),
        .cause(cause), .serving(serving)
    );

    always_comb begin
        win_data = '0;
        for (int w = 0; w < int'(NWIN); w++)
            if (win_sel == SW'(w)) win_data = irq_lines[w*WW +: WW];
    end

    assign next_irq = found ? {1'b0, {PADW{1'b0}}, pick_idx, 2'b00}
                            : {1'b1, {PADW{1'b0}}, {IW{1'b0}}, 2'b00};

    always_comb begin
        status     = '0;
        status[7]  = timer_pend;
        status[11] = ext_req;
    end

    AST_NEXT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        next_irq[1:0] == 2'b00); // R3
    AST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !take) |=> ext_req); // R5
    AST_NO_REQ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !found |=> !ext_req); // R5
endmodule

// File: tb/sim_vec_irq_hub.sv
module sim_vec_irq_hub;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] irq_lines;
    logic        timer_pend;
    logic        en_we, en_bit, pri_we;
    logic [4:0]  en_idx, pri_idx;
    logic [3:0]  pri_val;
    logic [0:0]  win_sel;
    logic        take, ret;
    logic [15:0] win_data;
    logic [31:0] next_irq, status, cause;
    logic        ext_req, serving;
    logic [4:0]  cur_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_irq_hub u0 (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .timer_pend(timer_pend),
        .en_we(en_we), .en_idx(en_idx), .en_bit(en_bit),
        .pri_we(pri_we), .pri_idx(pri_idx), .pri_val(pri_val),
        .win_sel(win_sel), .take(take), .ret(ret),
        .win_data(win_data), .next_irq(next_irq), .status(status),
        .ext_req(ext_req), .cause(cause), .cur_level(cur_level), .serving(serving)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_en(input int i, input logic v);
        en_we = 1'b1; en_idx = 5'(i); en_bit = v;
        tick();
        en_we = 1'b0;
    endtask

    task automatic set_pri(input int i, input int p);
        pri_we = 1'b1; pri_idx = 5'(i); pri_val = 4'(p);
        tick();
        pri_we = 1'b0;
    endtask

    task automatic pulse_take();
        take = 1'b1; tick(); take = 1'b0;
    endtask

    task automatic pulse_ret();
        ret = 1'b1; tick(); ret = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int reqs;
        rst_n = 1'b0; irq_lines = '0; timer_pend = 1'b1;
        en_we = 0; en_bit = 0; en_idx = 0; pri_we = 0; pri_idx = 0; pri_val = 0;
        win_sel = 0; take = 0; ret = 0;
        @(negedge clk); tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 ext_req", {31'b0, ext_req}, 32'd0);
        chk("R1 cause", cause, 32'd0);
        chk("R1 level", {27'b0, cur_level}, 32'd0);
        chk("R1 serving", {31'b0, serving}, 32'd0);
        irq_lines = '1;
        tick();
        chk("R1 enables zero, no winner", next_irq, 32'h8000_0000);
        chk("R7 status idle", status, 32'h0000_0080);

        // R9 sweep: every line pending, enable from the top down
        reqs = 0;
        for (int i = 31; i >= 0; i--) begin
            set_en(i, 1'b1);
            tick();
            chk("R5 request after enable", {31'b0, ext_req}, 32'd1);
            if (ext_req) reqs++;
            chk("R3 scaled index", next_irq, 32'(4 * i));
            chk("R7 status with request", status, 32'h0000_0880);
            win_sel = 1'b0; #1;
            chk("R2 low window", {16'b0, win_data}, {16'b0, irq_lines[15:0]});
            win_sel = 1'b1; #1;
            chk("R2 high window", {16'b0, win_data}, {16'b0, irq_lines[31:16]});
            pulse_take();
            chk("R6 request dropped", {31'b0, ext_req}, 32'd0);
            chk("R6 cause", cause, 32'h8000_000B);
            chk("R6 level", {27'b0, cur_level}, 32'd1);
            chk("R7 timer kept", status, 32'h0000_0080);
            irq_lines[i] = 1'b0;
            #1;
            chk("R10 line withdrawn", next_irq, 32'h8000_0000);
            pulse_ret();
            chk("R8 level restored", {27'b0, cur_level}, 32'd0);
            chk("R8 serving cleared", {31'b0, serving}, 32'd0);
            tick();
            chk("R9 single request", {31'b0, ext_req}, 32'd0);
        end
        chk("R9 request count", 32'(reqs), 32'd32);

        // R4 priority ordering and tie-break
        set_pri(3, 5); set_pri(10, 5); set_pri(20, 2);
        irq_lines = 32'h0010_0408;
        tick();
        chk("R4 tie to lower line", next_irq, 32'd12);
        win_sel = 1'b0; #1;
        chk("R2 sparse low", {16'b0, win_data}, 32'h0000_0408);
        pulse_take();
        chk("R6 level prio+1", {27'b0, cur_level}, 32'd6);
        chk("R4 masked below level", next_irq, 32'h8000_0000);
        pulse_take();
        chk("R8 take ignored in serve", {27'b0, cur_level}, 32'd6);
        pulse_ret();
        chk("R8 restore", {27'b0, cur_level}, 32'd0);
        pulse_ret();
        chk("R8 ret ignored in run", {27'b0, cur_level}, 32'd0);
        irq_lines[3] = 1'b0;
        #1;
        chk("R10 next after drop", next_irq, 32'd40);
        set_pri(20, 7);
        chk("R4 higher prio wins", next_irq, 32'd80);
        timer_pend = 1'b0;
        tick();
        chk("R7 timer bit follows", status, 32'h0000_0800);
        irq_lines = '0;
        tick(); tick();
        chk("R5 request falls", {31'b0, ext_req}, 32'd0);
        chk("R3 none flag", next_irq, 32'h8000_0000);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule